// File: doc/BRIEF.md
# Passive Serial Configuration Master

This block loads a configuration image into a target programmable device over a two-wire passive serial link, a serial clock and one data line. It starts by requesting a reconfiguration on an active-low request line and confirms that the target enters reset. It then releases the request and polls the target's active-low status line at a fixed interval, within a bounded number of polls. When the target leaves reset and a settling gap has passed, the block streams image bytes taken from a byte-wide valid/ready input.

When the last byte has gone out, the block checks the status line and, if enabled, a configuration-done input. It then sends one all-zero byte whose clock edges let the target finish initialization. The block reports either success or one error code. All timing is counted in system clock cycles and derived from the clock frequency parameter. A profile input selects one of two timing sets: profile 0 has a 2 µs settle gap and a 1506 µs status window; profile 1 has a 10 µs settle gap and a 3000 µs status window.

Top module: `ps_cfg_master`

## Requirements
- R1: After reset, and whenever idle, `cfg_n` is 1, `sclk` is 0, `busy`, `done` and `s_ready` are 0. `err_code` encodes 0 none, 1 no-reset, 2 not-ready, 3 config-error, 4 no-conf-done, 5 partial-rejected, and takes no other value.
- R2: A start in idle with `partial_req` set gives `err_code` 5 on the next cycle, leaves `busy` at 0 and never drives `cfg_n` low.
- R3: An accepted start drives `cfg_n` low for T_CFG (2 µs) worth of cycles. If `status_n` is not low at the end of that hold, the run ends with `err_code` 1 and `cfg_n` released.
- R4: After release, `status_n` is sampled every 268 µs, up to ceil(max/268) times (6 for profile 0, 12 for profile 1). If it never reads high, the run ends with `err_code` 2 exactly at the last poll, 1608 cycles after release for profile 0 at one cycle per µs.
- R5: Once `status_n` is seen high at a poll, no serial clock edge occurs until the profile's settle gap has elapsed (10 cycles per µs-scale for profile 1). A target leaving reset only after the 7th poll is still served under profile 1.
- R6: With `lsb_first` clear, each byte is sent bit 0 first; with it set, bit 7 first. `sdata` changes only while `sclk` falls or is idle and is stable across each rising edge. `sclk` idles low.
- R7: If `status_n` is low when the last data byte completes, the run ends with `err_code` 3 and no trailing byte is clocked.
- R8: With the config-done check enabled, a low `conf_done` at the end of the load ends the run with `err_code` 4 and no trailing byte.
- R9: On a clean end the block clocks one extra byte of eight zero bits, then raises `done` with `err_code` 0.
- R10: A start request while `busy` is ignored, including one carrying `partial_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start a load (accepted only when idle) |
| partial_req | input | 1 | Start asks for partial reconfiguration (refused) |
| lsb_first | input | 1 | Bytes already bit-reversed: send bit 7 first |
| profile_sel | input | 1 | Timing profile: 0 short window, 1 long window |
| cfg_n | output | 1 | Active-low configuration request to the target |
| status_n | input | 1 | Active-low target status (low = reset or error) |
| conf_done | input | 1 | Target configuration-done flag |
| s_data | input | 8 | Image byte |
| s_valid | input | 1 | Image byte valid |
| s_last | input | 1 | Marks the final image byte |
| s_ready | output | 1 | Block takes the byte this cycle |
| sclk | output | 1 | Serial clock to the target |
| sdata | output | 1 | Serial data to the target |
| busy | output | 1 | A load is in progress |
| done | output | 1 | Last load ended cleanly |
| err_code | output | 3 | Result code of the last start (see R1) |

## Verification
The load runs with both bit orders and both profiles over bytes such as 0xA5, 0x01, 0x3C, 0x80, 0x96 and 0x0F. Asymmetric bytes show a reversed bit order, and a scoreboard of expected serial bits catches any missing or extra clock edge, including the zero trailer. The target model can hold status high during the request, never leave reset, leave only just before the 7th poll, or fall back into error at the end, and `conf_done` can be held low. Each of these paths gives its own error code. The late exit separates the two poll budgets, and the gap before the first clock separates the two settle times. The poll count is measured by cycles from release to the not-ready error.

// File: rtl/ps_cfg_pkg.sv
package ps_cfg_pkg;

   typedef enum logic [2:0] {
      PSC_OK        = 3'd0,
      PSC_NO_RESET  = 3'd1,
      PSC_NOT_READY = 3'd2,
      PSC_CFG_ERR   = 3'd3,
      PSC_NO_DONE   = 3'd4,
      PSC_PARTIAL   = 3'd5
   } psc_err_e;

   typedef enum logic [2:0] {
      S_IDLE,
      S_HOLD,
      S_POLL,
      S_SETTLE,
      S_STREAM,
      S_FINAL,
      S_TRAIL
   } psc_state_e;

   function automatic int unsigned psc_ceil_div(int unsigned a, int unsigned b);
      return (a + b - 1) / b;
   endfunction

   function automatic int unsigned psc_max(int unsigned a, int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ps_cfg_timer.sv
module ps_cfg_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/ps_cfg_shifter.sv
module ps_cfg_shifter #(
   parameter int unsigned SCLK_DIV = 4,
   parameter int unsigned BYTE_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [BYTE_W-1:0] load_byte,
   input  logic              msb_first,
   output logic              busy,
   output logic              sclk,
   output logic              sdata
);

   localparam int unsigned DIV_W = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
   localparam int unsigned BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [DIV_W-1:0] DIV_END = DIV_W'(SCLK_DIV - 1);
   localparam logic [BIT_W-1:0] BIT_END = BIT_W'(BYTE_W - 1);

   if (SCLK_DIV < 1) begin : g_bad_div
      $error("ps_cfg_shifter: SCLK_DIV must be at least 1");
   end

   logic [BYTE_W-1:0] rev_byte;
   for (genvar i = 0; i < BYTE_W; i++) begin : g_rev
      assign rev_byte[i] = load_byte[BYTE_W-1-i];
   end

   logic [BYTE_W-1:0] sh_q;
   logic [DIV_W-1:0]  div_q;
   logic [BIT_W-1:0]  bit_q;
   logic              busy_q;
   logic              sclk_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         div_q  <= '0;
         bit_q  <= '0;
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
      end else if (load) begin
         sh_q   <= msb_first ? rev_byte : load_byte;
         div_q  <= '0;
         bit_q  <= '0;
         busy_q <= 1'b1;
         sclk_q <= 1'b0;
      end else if (busy_q) begin
         if (div_q == DIV_END) begin
            div_q <= '0;
            if (!sclk_q) begin
               sclk_q <= 1'b1;
            end else begin
               sclk_q <= 1'b0;
               if (bit_q == BIT_END) begin
                  busy_q <= 1'b0;
               end else begin
                  bit_q <= bit_q + 1'b1;
                  sh_q  <= sh_q >> 1;
               end
            end
         end else begin
            div_q <= div_q + 1'b1;
         end
      end
   end

   assign busy  = busy_q;
   assign sclk  = sclk_q;
   assign sdata = busy_q & sh_q[0];

endmodule

// File: rtl/ps_cfg_master.sv
module ps_cfg_master
   import ps_cfg_pkg::*;
#(
   parameter int unsigned CLK_FREQ_HZ   = 50_000_000,
   parameter int unsigned SCLK_DIV      = 4,
   parameter bit          USE_CONF_DONE = 1'b1,
   parameter int unsigned T_CFG_US      = 2,
   parameter int unsigned POLL_US       = 268,
   parameter int unsigned WIN0_US       = 1506,
   parameter int unsigned WIN1_US       = 3000,
   parameter int unsigned SETTLE0_US    = 2,
   parameter int unsigned SETTLE1_US    = 10
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start,
   input  logic       partial_req,
   input  logic       lsb_first,
   input  logic       profile_sel,
   output logic       cfg_n,
   input  logic       status_n,
   input  logic       conf_done,
   input  logic [7:0] s_data,
   input  logic       s_valid,
   input  logic       s_last,
   output logic       s_ready,
   output logic       sclk,
   output logic       sdata,
   output logic       busy,
   output logic       done,
   output logic [2:0] err_code
);

   localparam int unsigned CYC_US    = CLK_FREQ_HZ / 1_000_000;
   localparam int unsigned T_CFG_C   = T_CFG_US * CYC_US;
   localparam int unsigned POLL_C    = POLL_US * CYC_US;
   localparam int unsigned SETTLE0_C = SETTLE0_US * CYC_US;
   localparam int unsigned SETTLE1_C = SETTLE1_US * CYC_US;
   localparam int unsigned NPOLL0    = psc_ceil_div(WIN0_US, POLL_US);
   localparam int unsigned NPOLL1    = psc_ceil_div(WIN1_US, POLL_US);
   localparam int unsigned TMR_MAX   = psc_max(psc_max(T_CFG_C, POLL_C),
                                               psc_max(SETTLE0_C, SETTLE1_C));
   localparam int unsigned TMR_W     = $clog2(TMR_MAX + 1);
   localparam int unsigned PC_W      = $clog2(psc_max(NPOLL0, NPOLL1) + 1);

   localparam logic [TMR_W-1:0] TV_CFG  = TMR_W'(T_CFG_C - 1);
   localparam logic [TMR_W-1:0] TV_POLL = TMR_W'(POLL_C - 1);
   localparam logic [TMR_W-1:0] TV_SET0 = TMR_W'(SETTLE0_C - 1);
   localparam logic [TMR_W-1:0] TV_SET1 = TMR_W'(SETTLE1_C - 1);
   localparam logic [PC_W-1:0]  PC_END0 = PC_W'(NPOLL0 - 1);
   localparam logic [PC_W-1:0]  PC_END1 = PC_W'(NPOLL1 - 1);

   if (CYC_US < 1) begin : g_bad_freq
      $error("ps_cfg_master: CLK_FREQ_HZ must be at least 1 MHz");
   end
   if (T_CFG_US == 0 || POLL_US == 0 || SETTLE0_US == 0 || SETTLE1_US == 0) begin : g_bad_time
      $error("ps_cfg_master: every timing parameter must be nonzero");
   end
   if (WIN0_US == 0 || WIN1_US == 0) begin : g_bad_win
      $error("ps_cfg_master: status windows must be nonzero");
   end

   logic cd_ok;
   if (USE_CONF_DONE) begin : g_cd_on
      assign cd_ok = conf_done;
   end else begin : g_cd_off
      assign cd_ok = 1'b1;
   end

   psc_state_e       st_q, st_d;
   psc_err_e         err_q, err_d;
   logic             done_q, done_d;
   logic             cfg_q, cfg_d;
   logic [PC_W-1:0]  pc_q, pc_d;
   logic             last_q, last_d;
   logic             prof_q, prof_d;
   logic             lsbf_q, lsbf_d;

   logic             tmr_load;
   logic [TMR_W-1:0] tmr_val;
   logic             tmr_exp;
   logic             sh_load;
   logic [7:0]       sh_byte;
   logic             sh_busy;
   logic             take;

   ps_cfg_timer #(.CNT_W(TMR_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   ps_cfg_shifter #(.SCLK_DIV(SCLK_DIV), .BYTE_W(8)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sh_load),
      .load_byte (sh_byte),
      .msb_first (lsbf_q),
      .busy      (sh_busy),
      .sclk      (sclk),
      .sdata     (sdata)
   );

   assign s_ready = (st_q == S_STREAM) && !last_q && !sh_busy;
   assign take    = s_ready && s_valid;

   always_comb begin
      st_d     = st_q;
      err_d    = err_q;
      done_d   = done_q;
      cfg_d    = cfg_q;
      pc_d     = pc_q;
      last_d   = last_q;
      prof_d   = prof_q;
      lsbf_d   = lsbf_q;
      tmr_load = 1'b0;
      tmr_val  = TV_POLL;
      sh_load  = 1'b0;
      sh_byte  = s_data;
      unique case (st_q)
         S_IDLE: begin
            if (start) begin
               done_d = 1'b0;
               if (partial_req) begin
                  err_d = PSC_PARTIAL;
               end else begin
                  err_d    = PSC_OK;
                  cfg_d    = 1'b0;
                  prof_d   = profile_sel;
                  lsbf_d   = lsb_first;
                  tmr_load = 1'b1;
                  tmr_val  = TV_CFG;
                  st_d     = S_HOLD;
               end
            end
         end
         S_HOLD: begin
            if (tmr_exp) begin
               cfg_d = 1'b1;
               if (status_n) begin
                  err_d = PSC_NO_RESET;
                  st_d  = S_IDLE;
               end else begin
                  pc_d     = '0;
                  tmr_load = 1'b1;
                  tmr_val  = TV_POLL;
                  st_d     = S_POLL;
               end
            end
         end
         S_POLL: begin
            if (tmr_exp) begin
               if (status_n) begin
                  tmr_load = 1'b1;
                  tmr_val  = prof_q ? TV_SET1 : TV_SET0;
                  st_d     = S_SETTLE;
               end else if (pc_q == (prof_q ? PC_END1 : PC_END0)) begin
                  err_d = PSC_NOT_READY;
                  st_d  = S_IDLE;
               end else begin
                  pc_d     = pc_q + 1'b1;
                  tmr_load = 1'b1;
                  tmr_val  = TV_POLL;
               end
            end
         end
         S_SETTLE: begin
            if (tmr_exp) begin
               last_d = 1'b0;
               st_d   = S_STREAM;
            end
         end
         S_STREAM: begin
            if (last_q) begin
               if (!sh_busy) st_d = S_FINAL;
            end else if (take) begin
               sh_load = 1'b1;
               last_d  = s_last;
            end
         end
         S_FINAL: begin
            if (!status_n) begin
               err_d = PSC_CFG_ERR;
               st_d  = S_IDLE;
            end else if (!cd_ok) begin
               err_d = PSC_NO_DONE;
               st_d  = S_IDLE;
            end else begin
               sh_load = 1'b1;
               sh_byte = 8'h00;
               st_d    = S_TRAIL;
            end
         end
         S_TRAIL: begin
            if (!sh_busy) begin
               done_d = 1'b1;
               st_d   = S_IDLE;
            end
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         err_q  <= PSC_OK;
         done_q <= 1'b0;
         cfg_q  <= 1'b1;
         pc_q   <= '0;
         last_q <= 1'b0;
         prof_q <= 1'b0;
         lsbf_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         err_q  <= err_d;
         done_q <= done_d;
         cfg_q  <= cfg_d;
         pc_q   <= pc_d;
         last_q <= last_d;
         prof_q <= prof_d;
         lsbf_q <= lsbf_d;
      end
   end

   assign cfg_n    = cfg_q;
   assign busy     = (st_q != S_IDLE);
   assign done     = done_q;
   assign err_code = err_q;

endmodule

// File: rtl/ps_cfg_checker.sv
module ps_cfg_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       partial_req,
   input logic       cfg_n,
   input logic       s_ready,
   input logic       sclk,
   input logic       sdata,
   input logic       busy,
   input logic       done,
   input logic [2:0] err_code
);

   assert_err_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
      err_code <= 3'd5);

   assert_partial_reject_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (start && partial_req && !busy) |=> (err_code == 3'd5 && cfg_n && !busy));

   assert_cfg_low_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_n |-> (busy && !sclk));

   assert_sclk_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(sdata));

   assert_ready_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      s_ready |-> (busy && cfg_n));

   assert_done_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err_code == 3'd0 && !busy));

   assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> (err_code != 3'd5));

endmodule

bind ps_cfg_master ps_cfg_checker u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .partial_req (partial_req),
   .cfg_n       (cfg_n),
   .s_ready     (s_ready),
   .sclk        (sclk),
   .sdata       (sdata),
   .busy        (busy),
   .done        (done),
   .err_code    (err_code)
);

// File: tb/ps_cfg_master_tb.sv
module ps_cfg_master_tb;

   localparam int POLL_CYC   = 268;
   localparam int NPOLL_P0   = 6;
   localparam int T_CFG_CYC  = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       partial_req = 1'b0;
   logic       lsb_first = 1'b0;
   logic       profile_sel = 1'b0;
   logic       cfg_n;
   logic       status_n = 1'b1;
   logic       conf_done = 1'b1;
   logic [7:0] s_data = 8'h00;
   logic       s_valid = 1'b0;
   logic       s_last = 1'b0;
   logic       s_ready;
   logic       sclk;
   logic       sdata;
   logic       busy;
   logic       done;
   logic [2:0] err_code;

   always #10 clk = ~clk;

   ps_cfg_master #(
      .CLK_FREQ_HZ   (1_000_000),
      .SCLK_DIV      (2),
      .USE_CONF_DONE (1'b1)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .start (start), .partial_req (partial_req),
      .lsb_first (lsb_first), .profile_sel (profile_sel), .cfg_n (cfg_n),
      .status_n (status_n), .conf_done (conf_done), .s_data (s_data),
      .s_valid (s_valid), .s_last (s_last), .s_ready (s_ready), .sclk (sclk),
      .sdata (sdata), .busy (busy), .done (done), .err_code (err_code)
   );

   int total = 0;
   int bad = 0;
   int cyc = 0;

   bit exp_q[$];
   logic [7:0] byte_q[$];

   int  cfg_low_cnt = 0;
   int  cfg_rise_cyc = 0;
   int  first_rise = -1;
   int  rise_cnt = 0;
   int  st_rise_cyc = 0;
   logic sclk_prev = 1'b0;
   logic cfg_prev = 1'b1;

   bit  tgt_respond = 1'b1;
   bit  tgt_fault = 1'b0;
   int  tgt_delay = 300;
   int  rel_cnt = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // monitor, scoreboard consumer and target model share one process
   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (sclk && !sclk_prev) begin
            rise_cnt++;
            if (first_rise < 0) first_rise = cyc;
            if (exp_q.size() == 0) begin
               check(1'b0, "R6 unexpected serial clock", 1, 0);
            end else begin
               bit e;
               e = exp_q.pop_front();
               check(sdata == e, "R6 serial bit", int'(sdata), int'(e));
            end
         end
         if (!cfg_n) cfg_low_cnt++;
         if (cfg_n && !cfg_prev) cfg_rise_cyc = cyc;
      end
      sclk_prev = sclk;
      cfg_prev  = cfg_n;
      if (!cfg_n) begin
         rel_cnt  = 0;
         status_n = tgt_respond ? 1'b0 : 1'b1;
      end else if (tgt_fault) begin
         status_n = 1'b0;
      end else if (!status_n) begin
         rel_cnt++;
         if (rel_cnt >= tgt_delay) begin
            status_n    = 1'b1;
            st_rise_cyc = cyc;
         end
      end
   end

   task automatic kick(input bit prof, input bit lsbf, input bit part);
      @(negedge clk);
      cfg_low_cnt = 0;
      first_rise  = -1;
      rise_cnt    = 0;
      profile_sel = prof;
      lsb_first   = lsbf;
      partial_req = part;
      start       = 1'b1;
      @(negedge clk);
      start       = 1'b0;
      partial_req = 1'b0;
   endtask

   // driver: hands bytes to the design and pushes expected serial bits
   task automatic send_all(input bit lsbf, input bit want_trailer);
      for (int i = 0; i < byte_q.size(); i++) begin
         s_data  = byte_q[i];
         s_valid = 1'b1;
         s_last  = (i == byte_q.size() - 1);
         do @(negedge clk); while (!s_ready);
         for (int k = 0; k < 8; k++)
            exp_q.push_back(lsbf ? byte_q[i][7-k] : byte_q[i][k]);
         if (want_trailer && s_last)
            for (int k = 0; k < 8; k++) exp_q.push_back(1'b0);
         @(negedge clk);
      end
      s_valid = 1'b0;
      s_last  = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (busy);
   endtask

   task automatic finish_run();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(cfg_n == 1'b1, "R1 cfg_n idle", int'(cfg_n), 1);
      check(!sclk && !busy && !s_ready, "R1 sclk/busy/ready idle", int'({sclk, busy, s_ready}), 0);
      check(!done && err_code == 3'd0, "R1 done/err idle", int'({done, err_code}), 0);

      // R2 partial request rejected
      kick(1'b0, 1'b0, 1'b1);
      check(err_code == 3'd5, "R2 err code", int'(err_code), 5);
      check(!busy, "R2 not busy", int'(busy), 0);
      repeat (5) @(negedge clk);
      check(cfg_low_cnt == 0, "R2 cfg_n untouched", cfg_low_cnt, 0);

      // R3 target never shows reset
      tgt_respond = 1'b0;
      kick(1'b0, 1'b0, 1'b0);
      wait_idle();
      check(err_code == 3'd1, "R3 no-reset code", int'(err_code), 1);
      check(cfg_low_cnt >= T_CFG_CYC && cfg_low_cnt <= T_CFG_CYC + 1, "R3 hold length", cfg_low_cnt, T_CFG_CYC);
      check(cfg_n == 1'b1 && rise_cnt == 0, "R3 released, no clocks", int'(cfg_n) + rise_cnt * 2, 1);
      tgt_respond = 1'b1;

      // R4 target never leaves reset: poll budget of profile 0
      tgt_delay = 1000000;
      kick(1'b0, 1'b0, 1'b0);
      wait_idle();
      check(err_code == 3'd2, "R4 not-ready code", int'(err_code), 2);
      check((cyc - cfg_rise_cyc) >= NPOLL_P0 * POLL_CYC - 1 && (cyc - cfg_rise_cyc) <= NPOLL_P0 * POLL_CYC + 2,
            "R4 poll budget cycles", cyc - cfg_rise_cyc, NPOLL_P0 * POLL_CYC);

      // R6 R9 R10 clean load, profile 0, bit 0 first
      tgt_delay = 300;
      byte_q = '{8'hA5, 8'h01, 8'h3C};
      kick(1'b0, 1'b0, 1'b0);
      send_all(1'b0, 1'b1);
      start = 1'b1; partial_req = 1'b1;   // R10 start while busy
      @(negedge clk);
      start = 1'b0; partial_req = 1'b0;
      wait_idle();
      check(done == 1'b1, "R9 done", int'(done), 1);
      check(err_code == 3'd0, "R10 err after busy start", int'(err_code), 0);
      check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);
      check(rise_cnt == 32, "R9 clocks incl trailer", rise_cnt, 32);
      check(!sclk && cfg_n, "R6 idle low clock", int'(sclk), 0);

      // R5 R6 profile 1, late exit just before 7th poll, bit 7 first
      tgt_delay = 7 * POLL_CYC - 3;
      byte_q = '{8'h80, 8'h96, 8'h0F};
      kick(1'b1, 1'b1, 1'b0);
      send_all(1'b1, 1'b1);
      wait_idle();
      check(done && err_code == 3'd0, "R5 long budget success", int'(err_code), 0);
      check((first_rise - st_rise_cyc) >= 12 && (first_rise - st_rise_cyc) <= 22,
            "R5 settle gap", first_rise - st_rise_cyc, 17);
      check(exp_q.size() == 0 && rise_cnt == 32, "R6 msb-first scoreboard", rise_cnt, 32);

      // R7 status falls back at end of load
      tgt_delay = 300;
      byte_q = '{8'h5A, 8'hC3};
      kick(1'b0, 1'b0, 1'b0);
      send_all(1'b0, 1'b0);
      tgt_fault = 1'b1;
      wait_idle();
      tgt_fault = 1'b0;
      check(err_code == 3'd3, "R7 config-error code", int'(err_code), 3);
      check(rise_cnt == 16 && !done, "R7 no trailer", rise_cnt, 16);

      // R8 config-done not raised
      conf_done = 1'b0;
      byte_q = '{8'h77};
      kick(1'b0, 1'b0, 1'b0);
      send_all(1'b0, 1'b0);
      wait_idle();
      conf_done = 1'b1;
      check(err_code == 3'd4, "R8 no-conf-done code", int'(err_code), 4);
      check(rise_cnt == 8 && !done, "R8 no trailer", rise_cnt, 8);
      check(exp_q.size() == 0, "R8 scoreboard drained", exp_q.size(), 0);

      finish_run();
   end

endmodule